// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is the data store of a small 32-bit processor core. Its storage is organised as 32-bit words, and the core addresses it in bytes. A single access can move a byte, a halfword or a full word. A store updates only the byte lanes that the access covers, and the other lanes of the word keep their contents. A load takes the addressed lanes out of the stored word and widens them to 32 bits, using either zero or sign extension.

The core drives a byte address, a 2-bit size code, a write strobe, the store data and a signed-load select. It reads the load result from a combinational output, so a load completes in the same cycle as its address. Stores take effect on the rising clock edge. Misaligned addresses raise no trap: a halfword access uses only address bit 1, and a word access ignores the two lowest address bits.

Top module: `byte_dmem`

## Requirements
- R1: With size code 2'b10 (word), a store writes all 32 bits of `wrData` into the word that address bits above bit 1 select. A later load returns that word unchanged.
- R2: Size code 2'b11 behaves exactly like 2'b10 for both stores and loads.
- R3: With size code 2'b00 (byte), a store writes `wrData[7:0]` into lane `addr[1:0]` only. Lane k holds bits [8k+7:8k] of the word (little-endian), and the other three lanes keep their old values.
- R4: With size code 2'b01 (halfword), a store writes `wrData[7:0]` into lane {addr[1],0} and `wrData[15:8]` into lane {addr[1],1}. `addr[0]` is ignored, and the other halfword is kept.
- R5: A word access ignores `addr[1:0]`.
- R6: With `loadSigned` low, byte and halfword loads return the addressed lanes zero-extended to 32 bits.
- R7: With `loadSigned` high, byte and halfword loads return the addressed lanes sign-extended to 32 bits. `loadSigned` has no effect on word loads.
- R8: While `wrEn` is low, no clock edge changes any stored byte.
- R9: `rdData` is combinational. In the cycle in which a store to the same word is presented, it still shows the old contents, and it shows the new contents after that clock edge.
- R10: Address bits at and above bit log2(DEPTH)+2 are ignored, so addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores happen on its rising edge |
| addr | input | 32 | Byte address |
| accSize | input | 2 | 00 byte, 01 halfword, 10/11 word |
| wrEn | input | 1 | Store strobe |
| wrData | input | 32 | Store data, right-aligned for sub-word stores |
| loadSigned | input | 1 | 1 selects sign extension for sub-word loads |
| rdData | output | 32 | Extended load result |

## Verification
The bench stores a byte into each of the four lanes and a halfword into each half, and then reads back the whole word. This catches lane steering that is off by one lane or mirrored, and byte enables that disturb neighbouring lanes. Loads of values with the top bit set, done both signed and unsigned, expose extension that is missing or inverted. So do halfword loads that take the sign from the wrong byte. An odd-address halfword, a word at a misaligned address and size code 2'b11 reveal a design that decodes `addr[0]` or the spare size code wrongly. A store held with `wrEn` low, a read that falls in the same cycle as a store, and a high-address alias catch a memory that writes without the strobe, registers its output, or decodes too many address bits.

// File: rtl/byte_dmem_pkg.sv
package byte_dmem_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneWe;    // per-lane write enables, already gated by wrEn
    logic [1:0]       laneSel;   // lowest lane of the access
    logic             isByte;
    logic             isHalf;
    logic             signExt;
  } dmemStrobe_t;

endpackage

// File: rtl/byte_dmem_ctrl.sv
module byte_dmem_ctrl
  import byte_dmem_pkg::*;
(
  input  logic [1:0]  addrLow,
  input  logic [1:0]  accSize,
  input  logic        wrEn,
  input  logic        loadSigned,
  output dmemStrobe_t strobe
);

  accSize_e sizeCode;
  logic [LANES-1:0] laneMask;

  assign sizeCode = accSize_e'(accSize);

  always_comb begin
    strobe = '0;
    laneMask = '1;
    unique case (sizeCode)
      SZ_BYTE: begin
        laneMask = LANES'(1) << addrLow;
        strobe.isByte = 1'b1;
        strobe.laneSel = addrLow;
      end
      SZ_HALF: begin
        laneMask = addrLow[1] ? 4'b1100 : 4'b0011;
        strobe.isHalf = 1'b1;
        strobe.laneSel = {addrLow[1], 1'b0};
      end
      default: begin
        laneMask = '1;
        strobe.laneSel = 2'b00;
      end
    endcase
    strobe.laneWe = wrEn ? laneMask : '0;
    strobe.signExt = loadSigned;
  end

  // Lane-enable population must match the access size
  always_comb begin
    if (wrEn && sizeCode == SZ_BYTE)
      assert_byte_one_lane_R3: assert ($countones(strobe.laneWe) == 1);
    if (wrEn && sizeCode == SZ_HALF)
      assert_half_two_lanes_R4: assert ($countones(strobe.laneWe) == 2 && !strobe.laneWe[{addrLow[1], 1'b0} ^ 2'b10]);
    if (wrEn && (sizeCode == SZ_WORD || sizeCode == SZ_WIDE))
      assert_word_all_lanes_R2: assert (&strobe.laneWe);
    if (!wrEn)
      assert_no_lane_without_we_R8: assert (strobe.laneWe == '0);
  end

endmodule

// File: rtl/byte_dmem_datapath.sv
module byte_dmem_datapath
  import byte_dmem_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  dmemStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] memWords [DEPTH];
  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] curWord;
  logic [7:0]        pickByte;
  logic [15:0]       pickHalf;

  // Replicate the low part of the store data across all lane positions
  always_comb begin
    if (strobe.isByte)      laneData = {LANES{wrData[7:0]}};
    else if (strobe.isHalf) laneData = {2{wrData[15:0]}};
    else                    laneData = wrData;
  end

  generate
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
      always_ff @(posedge clk) begin
        if (strobe.laneWe[lane])
          memWords[wordIdx][8*lane +: 8] <= laneData[8*lane +: 8];
      end
    end
  endgenerate

  assign curWord = memWords[wordIdx];

  always_comb begin
    unique case (strobe.laneSel)
      2'd0: pickByte = curWord[7:0];
      2'd1: pickByte = curWord[15:8];
      2'd2: pickByte = curWord[23:16];
      default: pickByte = curWord[31:24];
    endcase
    pickHalf = strobe.laneSel[1] ? curWord[31:16] : curWord[15:0];
  end

  always_comb begin
    if (strobe.isByte)
      rdData = {{24{strobe.signExt & pickByte[7]}}, pickByte};
    else if (strobe.isHalf)
      rdData = {{16{strobe.signExt & pickHalf[15]}}, pickHalf};
    else
      rdData = curWord;
  end

  // Extension of sub-word loads
  always_comb begin
    if (strobe.isByte && !strobe.signExt)
      assert_byte_zero_ext_R6: assert (rdData[31:8] == 24'd0);
    if (strobe.isHalf && !strobe.signExt)
      assert_half_zero_ext_R6: assert (rdData[31:16] == 16'd0);
    if (strobe.isByte && strobe.signExt)
      assert_byte_sign_ext_R7: assert (rdData[31:8] == {24{rdData[7]}});
    if (strobe.isHalf && strobe.signExt)
      assert_half_sign_ext_R7: assert (rdData[31:16] == {16{rdData[15]}});
    if (!strobe.isByte && !strobe.isHalf)
      assert_word_passthru_R1: assert (rdData == memWords[wordIdx]);
  end

endmodule

// File: rtl/byte_dmem.sv
module byte_dmem
  import byte_dmem_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic [31:0] addr,
  input  logic [1:0]  accSize,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        loadSigned,
  output logic [31:0] rdData
);

  localparam int IDX_W = $clog2(DEPTH);

  dmemStrobe_t strobe;
  logic [IDX_W-1:0] wordIdx;
  logic unusedAddrBits;

  assign wordIdx = addr[IDX_W+1:2];
  assign unusedAddrBits = ^addr[31:IDX_W+2];

  byte_dmem_ctrl u_ctrl (
    .addrLow    (addr[1:0]),
    .accSize    (accSize),
    .wrEn       (wrEn),
    .loadSigned (loadSigned),
    .strobe     (strobe)
  );

  byte_dmem_datapath #(.DEPTH(DEPTH)) u_datapath (
    .clk     (clk),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData)
  );

endmodule

// File: tb/byte_dmem_bench.sv
module byte_dmem_bench;

  localparam int DEPTH = 1024;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SPAN  = 16;

  logic        clk = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  accSize = 2'b10;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        loadSigned = 1'b0;
  logic [31:0] rdData;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [SPAN];

  always #5 clk = ~clk;

  byte_dmem #(.DEPTH(DEPTH)) u_byte_dmem (
    .clk(clk), .addr(addr), .accSize(accSize), .wrEn(wrEn),
    .wrData(wrData), .loadSigned(loadSigned), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expLoad(input logic [31:0] a, input logic [1:0] sz, input logic sgn);
    logic [31:0] w = model[a[5:2]];
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*a[1:0] +: 8];
    h = a[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return sgn ? {{24{b[7]}}, b} : {24'd0, b};
    if (sz == 2'b01) return sgn ? {{16{h[15]}}, h} : {16'd0, h};
    return w;
  endfunction

  task automatic modelStore(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) model[a[5:2]][8*a[1:0] +: 8] = d[7:0];
    else if (sz == 2'b01) begin
      if (a[1]) model[a[5:2]][31:16] = d[15:0];
      else      model[a[5:2]][15:0]  = d[15:0];
    end else model[a[5:2]] = d;
  endtask

  task automatic store(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    addr = a; accSize = sz; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelStore(a, sz, d);
  endtask

  task automatic load(input logic [31:0] a, input logic [1:0] sz, input logic sgn, output logic [31:0] q);
    @(negedge clk);
    addr = a; accSize = sz; loadSigned = sgn; wrEn = 1'b0;
    #1 q = rdData;
  endtask

  function automatic string tagFor(input logic [1:0] sz, input logic sgn);
    if (sz == 2'b11) return "R2";
    if (sz == 2'b10) return "R1";
    return sgn ? "R7" : "R6";
  endfunction

  initial begin : watchdog
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] q;
    void'($urandom(32'h1234_5a5a));
    repeat (3) @(negedge clk);

    for (int i = 0; i < SPAN; i++) store(32'(i*4), 2'b10, 32'h1111_1111 * (i + 1));
    for (int i = 0; i < SPAN; i++) begin
      load(32'(i*4), 2'b10, 1'b0, q);
      check("R1", q, model[i]);
    end

    // R3: each byte lane in turn, others kept
    for (int k = 0; k < 4; k++) begin
      store(32'h0 + 32'(k), 2'b00, 32'hFFFF_FF80 | 32'(k));
      load(32'h0, 2'b10, 1'b0, q);
      check("R3", q, model[0]);
    end
    load(32'h2, 2'b00, 1'b1, q); check("R7", q, 32'hFFFF_FF82);
    load(32'h2, 2'b00, 1'b0, q); check("R6", q, 32'h0000_0082);

    // R4: halfword at odd addresses
    store(32'h5, 2'b01, 32'hABCD_9876);
    load(32'h4, 2'b10, 1'b0, q); check("R4", q, model[1]);
    check("R4", q[15:0], 16'h9876);
    store(32'h7, 2'b01, 32'h0000_C3A5);
    load(32'h4, 2'b10, 1'b0, q); check("R4", q, 32'hC3A5_9876);
    load(32'h6, 2'b01, 1'b1, q); check("R7", q, 32'hFFFF_C3A5);
    load(32'h7, 2'b01, 1'b0, q); check("R6", q, 32'h0000_C3A5);

    // R5, R2: misaligned word and spare size code
    store(32'hB, 2'b10, 32'hDEAD_BEEF);
    load(32'h9, 2'b11, 1'b1, q); check("R5", q, 32'hDEAD_BEEF);
    store(32'hE, 2'b11, 32'h8765_4321);
    load(32'hC, 2'b10, 1'b1, q); check("R2", q, 32'h8765_4321);

    // R8: no write while wrEn low
    @(negedge clk);
    addr = 32'h10; accSize = 2'b10; wrData = 32'h0BAD_0BAD; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    load(32'h10, 2'b10, 1'b0, q); check("R8", q, model[4]);

    // R9: same-cycle read shows old value
    @(negedge clk);
    addr = 32'h14; accSize = 2'b10; wrData = 32'h5555_AAAA; wrEn = 1'b1;
    #1 check("R9", rdData, model[5]);
    @(negedge clk);
    wrEn = 1'b0; modelStore(32'h14, 2'b10, 32'h5555_AAAA);
    #1 check("R9", rdData, 32'h5555_AAAA);

    // R10: high address bits alias
    store(32'h18 | (32'h1 << (IDX_W + 2)) | 32'h8000_0000, 2'b10, 32'h0F0F_F0F0);
    load(32'h18, 2'b10, 1'b0, q); check("R10", q, 32'h0F0F_F0F0);

    // Random mix within the prefilled span
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      logic        sgn;
      a = 32'($urandom % (SPAN * 4));
      sz = 2'($urandom);
      sgn = 1'($urandom);
      if ($urandom % 2) store(a, sz, $urandom);
      else begin
        load(a, sz, sgn, q);
        check(tagFor(sz, sgn), q, expLoad(a, sz, sgn));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule